// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block links two parallel ports, A and B, with one storage latch for each direction of transfer. On each side, data from the source port enters a level-sensitive latch. The value in the latch is then offered to the opposite port through a drive-enable qualified output. The A-to-B and B-to-A directions each have their own three active-low controls: a chip enable, a latch enable and an output enable. The two directions share no control, so each one decides on its own when it holds data and when it drives it.

The chip enable of a direction gates both the transparency of its latch and the drive onto the far port. A latch is open only while both its chip enable and its latch enable are low. Raising either of those two controls closes the latch and keeps the last captured word. The design is synchronous: every latch is a register that loads on each clock edge at which it is sampled open. Each port is split into an input word, an output word and a drive-enable bit instead of a bidirectional wire, so the block remains synthesizable. Reset clears both latches to zero, so an enabled output has a defined value before the first capture.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: If `ab_ce_n` and `ab_le_n` are both 0 at a rising `clk` edge, the A-to-B latch loads `a_in`, and `b_out` shows that word after the edge.
- R2: If `ab_ce_n` is 0 and `ab_le_n` is 1 at an edge, the A-to-B latch keeps its value. A rising `ab_le_n` therefore closes the latch on the word loaded at the last open edge.
- R3: If `ab_ce_n` is 1 at an edge, the A-to-B latch keeps its value whatever `ab_le_n` is. A rising `ab_ce_n` therefore also ends the transparent window.
- R4: `b_oe` is 1 exactly when `ab_ce_n` and `ab_oe_n` are both 0. It follows those inputs with no clock delay.
- R5: `b_out` always presents the A-to-B latch contents and never raw `a_in`. While the latch is closed, changes on `a_in` leave `b_out` unchanged.
- R6: The B-to-A direction behaves as in R1 to R5, using `ba_ce_n`, `ba_le_n`, `ba_oe_n`, `b_in`, `a_out` and `a_oe`.
- R7: The controls and data of one direction have no effect on the latch or the drive enable of the other direction.
- R8: While `rst_n` is 0, both latches are cleared, so `a_out` and `b_out` read 0.
- R9: Every bit is an independent identical channel across the `WIDTH`-bit word (default 8), so a single set bit passes through in its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; latches are sampled at its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both latches |
| a_in | input | WIDTH | Word present on port A, source for the A-to-B latch |
| a_out | output | WIDTH | B-to-A latch contents offered to port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | WIDTH | Word present on port B, source for the B-to-A latch |
| b_out | output | WIDTH | A-to-B latch contents offered to port B |
| b_oe | output | 1 | Drive enable for port B |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The assertions assume that every control and data input is settled before each rising clock edge, because the latch contents are defined only by the sampled values. The bench changes all inputs on the falling edge and reads the registered outputs on the next falling edge. It reads the drive enables shortly after each change. A bench resolver combines the bench's own drive of port A with `a_oe`. It releases port A whenever the block is expected to drive it, so the stimulus never sets up a bus contention that the assertions would have to tolerate.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        LM_OFF  = 2'b00,
        LM_OPEN = 2'b01,
        LM_HOLD = 2'b10
    } latch_mode_t;

    typedef struct packed {
        logic held;
    } cell_state_t;

    function automatic latch_mode_t decode_mode(input logic ce_n, input logic le_n);
        if (ce_n)
            return LM_OFF;
        else if (!le_n)
            return LM_OPEN;
        else
            return LM_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_bit_cell.sv
module xcvr_bit_cell
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic din,
    output logic dout
);

    cell_state_t st_d;
    cell_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (capture)
            st_d.held = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dout = st_q.held;

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             le_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst,
    output logic             drive
);

    latch_mode_t mode;
    logic        capture;

    always_comb begin
        mode    = decode_mode(ce_n, le_n);
        capture = (mode == LM_OPEN);
        drive   = !ce_n && !oe_n;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        xcvr_bit_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (capture),
            .din     (src[i]),
            .dout    (dst[i])
        );
    end

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe,
    input  logic             ab_ce_n,
    input  logic             ab_le_n,
    input  logic             ab_oe_n,
    input  logic             ba_ce_n,
    input  logic             ba_le_n,
    input  logic             ba_oe_n
);

    xcvr_dir_path #(.WIDTH(WIDTH)) ab_path_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ab_ce_n),
        .le_n  (ab_le_n),
        .oe_n  (ab_oe_n),
        .src   (a_in),
        .dst   (b_out),
        .drive (b_oe)
    );

    xcvr_dir_path #(.WIDTH(WIDTH)) ba_path_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ba_ce_n),
        .le_n  (ba_le_n),
        .oe_n  (ba_oe_n),
        .src   (b_in),
        .dst   (a_out),
        .drive (a_oe)
    );

endmodule

// File: rtl/bidir_latch_xcvr_chk.sv
module bidir_latch_xcvr_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] a_out,
    input logic             a_oe,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] b_out,
    input logic             b_oe,
    input logic             ab_ce_n,
    input logic             ab_le_n,
    input logic             ab_oe_n,
    input logic             ba_ce_n,
    input logic             ba_le_n,
    input logic             ba_oe_n
);

    assert_ab_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ce_n && !ab_le_n) |=> (b_out == $past(a_in)));

    assert_ab_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ce_n && ab_le_n) |=> $stable(b_out));

    assert_ab_ce_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ab_ce_n |=> $stable(b_out));

    assert_ab_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_ce_n || ab_oe_n) |-> !b_oe);

    assert_ab_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_ce_n && !ab_oe_n) |-> b_oe);

    assert_ba_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_ce_n && !ba_le_n) |=> (a_out == $past(b_in)));

    assert_ba_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_ce_n || ba_le_n) |=> $stable(a_out));

    assert_ba_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_ce_n || ba_oe_n) |-> !a_oe);

    assert_ba_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_ce_n && !ba_oe_n) |-> a_oe);

endmodule

bind bidir_latch_xcvr bidir_latch_xcvr_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .ab_ce_n (ab_ce_n),
    .ab_le_n (ab_le_n),
    .ab_oe_n (ab_oe_n),
    .ba_ce_n (ba_ce_n),
    .ba_le_n (ba_le_n),
    .ba_oe_n (ba_oe_n)
);

// File: tb/bidir_latch_xcvr_tb_top.sv
module bidir_latch_xcvr_tb_top;

    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_ce_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
    logic         ba_ce_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;

    logic [W-1:0] exp_b = '0, exp_a = '0;
    int           checks = 0, errors = 0;

    logic         a_ext_en;
    logic [W-1:0] a_bus;
    logic         a_clash;
    assign a_bus   = a_oe ? a_out : (a_ext_en ? a_in : '0);
    assign a_clash = a_oe && a_ext_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    bidir_latch_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string ab_tag(input logic ce, input logic le);
        if (ce) return "R3";
        if (le) return "R2";
        return "R1";
    endfunction

    // Sets inputs on a falling edge, checks drive enables, steps one clock,
    // updates the reference and checks the latched outputs on the next falling edge.
    task automatic step(input logic [2:0] ab, input logic [2:0] ba,
                        input logic [W-1:0] ad, input logic [W-1:0] bd);
        {ab_ce_n, ab_le_n, ab_oe_n} = ab;
        {ba_ce_n, ba_le_n, ba_oe_n} = ba;
        a_in = ad;
        b_in = bd;
        #1;
        chk("R4 b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, !ab[2] && !ab[0]});
        chk("R6 a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, !ba[2] && !ba[0]});
        chk("R7 no bus clash", {{(W-1){1'b0}}, a_clash}, '0);
        @(posedge clk);
        if (!ab[2] && !ab[1]) exp_b = ad;
        if (!ba[2] && !ba[1]) exp_a = bd;
        @(negedge clk);
        chk({ab_tag(ab[2], ab[1]), " b_out"}, b_out, exp_b);
        chk("R6/R7 a_out", a_out, exp_a);
        if (a_oe) chk("R6 resolved A bus", a_bus, exp_a);
    endtask

    always_comb a_ext_en = !((!ba_ce_n) && (!ba_oe_n));

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        a_in = 8'hA5;
        b_in = 8'h5A;
        ab_ce_n = 1'b0; ab_le_n = 1'b1;
        ba_ce_n = 1'b0; ba_le_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 reset b_out", b_out, '0);
        chk("R8 reset a_out", a_out, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: close on rising latch enable
        step(3'b000, 3'b111, 8'h3C, 8'h00);
        step(3'b010, 3'b111, 8'hC3, 8'h00);
        chk("R2 closed on le edge", b_out, 8'h3C);
        // R5: a_in changes while closed, b_out unchanged
        step(3'b010, 3'b111, 8'hFF, 8'h00);
        chk("R5 held not raw", b_out, 8'h3C);
        // R3: close on rising chip enable
        step(3'b000, 3'b111, 8'h81, 8'h00);
        step(3'b101, 3'b111, 8'h7E, 8'h00);
        chk("R3 closed on ce edge", b_out, 8'h81);
        step(3'b100, 3'b111, 8'h11, 8'h00);
        chk("R3 ce high le low holds", b_out, 8'h81);

        // R6 mirror edges
        step(3'b111, 3'b000, 8'h00, 8'h96);
        step(3'b111, 3'b010, 8'h00, 8'h69);
        chk("R6 closed on le edge", a_out, 8'h96);
        step(3'b111, 3'b000, 8'h00, 8'h42);
        step(3'b111, 3'b100, 8'h00, 8'h24);
        chk("R6 closed on ce edge", a_out, 8'h42);

        // R7: AB open while BA closed leaves a_out alone
        step(3'b000, 3'b010, 8'hEE, 8'h77);
        chk("R7 a_out untouched", a_out, 8'h42);
        chk("R7 b_out captured", b_out, 8'hEE);

        // R9: walking one in each bit position, both directions
        for (int i = 0; i < W; i++) begin
            step(3'b000, 3'b000, W'(1) << i, W'(1) << (W-1-i));
            chk("R9 bit b_out", b_out, W'(1) << i);
            chk("R9 bit a_out", a_out, W'(1) << (W-1-i));
        end

        // Sweep every control combination of both directions
        for (int rep = 0; rep < 4; rep++) begin
            for (int c = 0; c < 64; c++) begin
                step(3'(c), 3'(c >> 3), W'($urandom), W'($urandom));
            end
        end

        // R8: reset in the middle of operation
        step(3'b000, 3'b000, 8'h5F, 8'hF5);
        rst_n = 1'b0;
        #1;
        chk("R8 mid reset b_out", b_out, '0);
        chk("R8 mid reset a_out", a_out, '0);
        exp_a = '0;
        exp_b = '0;
        @(negedge clk);
        rst_n = 1'b1;
        step(3'b010, 3'b010, 8'h12, 8'h34);
        chk("R8 cleared stays after reset", b_out, '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule